// File: doc/BRIEF.md
# ALU Status Flag Generator

This block turns the outcome of one integer ALU operation into the six condition bits of a program status word: negative, zero, signed overflow, carry/borrow, nibble carry and even parity. The ALU supplies both operands, its result, the raw carry out of the top bit of the active width, an operation class and a width code. The block derives every flag from these inputs and loads the flags into a status register on each clock edge where the update enable is high.

The operation class picks how carry, overflow and nibble carry are read. Add and subtract use two's complement arithmetic. Logic operations clear the three arithmetic flags. The width code selects 8-, 16- or 32-bit operation. Negative, zero, overflow and carry are read at that width, and bits above it are ignored. Parity always looks at the low byte of the result.

Top module: `psw_flag_gen`

## Requirements
- R1: `flag_n` is the top bit of `alu_result` at the selected width.
- R2: `flag_z` is 1 exactly when every bit of `alu_result` inside the selected width is 0. Result bits above the width have no effect.
- R3: For add and subtract, `flag_v` is 1 when the true signed sum (`a+b`) or difference (`a-b`) of the operands, taken at the selected width, falls outside the signed range of that width.
- R4: For add (`op_cls` = 0), `flag_c` equals `alu_cout`. For subtract (`op_cls` = 1), the ALU forms `a + ~b + 1`, and `flag_c` is the borrow, which is the inverse of `alu_cout`. It is 1 when `a < b` unsigned at the width.
- R5: For add, `flag_a` is the carry out of bit 3 (`a[3:0]+b[3:0] > 15`). For subtract, it is the borrow out of bit 3 (`a[3:0] < b[3:0]`).
- R6: For logic classes (`op_cls` = 2 or 3), `flag_c`, `flag_v` and `flag_a` are 0 and `alu_cout` is ignored. `flag_n`, `flag_z` and `flag_p` still follow the result.
- R7: `flag_p` is 1 when `alu_result[7:0]` holds an even number of 1 bits, at every width.
- R8: On a clock edge with `upd_en` low, all six flags keep their values.
- R9: On a clock edge with `rst` high, all flags become 0, even when `upd_en` is high.
- R10: Width code `width_sel` 0 means 8 bits, 1 means 16 bits, and 2 or 3 mean 32 bits. Flags appear on the outputs after the clock edge that samples the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Load the flag register on this edge |
| op_cls | input | 2 | 0 add, 1 subtract, 2/3 logic |
| width_sel | input | 2 | 0 byte, 1 halfword, 2/3 word |
| opnd_a | input | 32 | First ALU operand |
| opnd_b | input | 32 | Second ALU operand |
| alu_result | input | 32 | ALU result |
| alu_cout | input | 1 | Raw adder carry out of the top bit of the selected width |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Carry (add) / borrow (subtract) |
| flag_a | output | 1 | Carry or borrow out of bit 3 |
| flag_p | output | 1 | Even parity of the low byte |

## Verification
Carry and overflow can be set in the same cycle, and the zero flag can be set along with them. The bench provokes this with an 8-bit `0x80 + 0x80`, which must yield C, V and Z together with even parity, and with random operands that wrap both ways. A second collision is a synchronous reset on the same edge as an enabled update with operands that set flags. There the bench expects all flags cleared, which shows that reset wins. All results are judged against a bench model that computes overflow from true signed sums and borrow from unsigned comparisons.

// File: rtl/psw_flag_pkg.sv
package psw_flag_pkg;

  typedef enum logic [1:0] {
    OPC_ADD   = 2'd0,
    OPC_SUB   = 2'd1,
    OPC_LOGIC = 2'd2,
    OPC_LOGX  = 2'd3
  } op_class_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic ovf;
    logic cry;
    logic aux;
    logic par;
  } flag_set_t;

endpackage

// File: rtl/psw_width_sel.sv
module psw_width_sel #(
  parameter int DATA_W = 32,
  parameter int BASE_W = 8,
  parameter int NUM_W  = 3
) (
  input  logic [1:0]        width_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] alu_result,
  output logic              a_msb,
  output logic              b_msb,
  output logic              r_msb,
  output logic              r_zero
);

  localparam int IDX_W = (NUM_W > 1) ? $clog2(NUM_W) : 1;

  logic [NUM_W-1:0] msb_a, msb_b, msb_r, zero_r;
  logic [IDX_W-1:0] idx;

  // one lane per supported width: 8, 16, 32 ...
  for (genvar g = 0; g < NUM_W; g++) begin : g_lane
    localparam int W = BASE_W << g;
    assign msb_a[g]  = opnd_a[W-1];
    assign msb_b[g]  = opnd_b[W-1];
    assign msb_r[g]  = alu_result[W-1];
    assign zero_r[g] = ~|alu_result[W-1:0];
  end

  // codes beyond the last lane fall back to the widest one
  always_comb begin
    if (int'(width_sel) >= NUM_W) idx = IDX_W'(NUM_W - 1);
    else                          idx = IDX_W'(width_sel);
  end

  assign a_msb  = msb_a[idx];
  assign b_msb  = msb_b[idx];
  assign r_msb  = msb_r[idx];
  assign r_zero = zero_r[idx];

endmodule

// File: rtl/psw_arith_flags.sv
module psw_arith_flags
  import psw_flag_pkg::*;
(
  input  op_class_e op,
  input  logic      a_msb,
  input  logic      b_msb,
  input  logic      r_msb,
  input  logic      a_nib,
  input  logic      b_nib,
  input  logic      r_nib,
  input  logic      alu_cout,
  output logic      ovf,
  output logic      cry,
  output logic      aux
);

  logic nib_carry;

  // carry (or borrow) into bit 4 recovered from the three bit-4 values
  assign nib_carry = a_nib ^ b_nib ^ r_nib;

  always_comb begin
    ovf = 1'b0;
    cry = 1'b0;
    aux = 1'b0;
    unique case (op)
      OPC_ADD: begin
        ovf = (a_msb == b_msb) && (r_msb != a_msb);
        cry = alu_cout;
        aux = nib_carry;
      end
      OPC_SUB: begin
        ovf = (a_msb != b_msb) && (r_msb != a_msb);
        cry = ~alu_cout;
        aux = nib_carry;
      end
      default: begin
        ovf = 1'b0;
        cry = 1'b0;
        aux = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/psw_flag_gen.sv
module psw_flag_gen
  import psw_flag_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int BASE_W  = 8,
  parameter int NUM_W   = 3,
  parameter int AUX_BIT = 4,
  parameter int PAR_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  logic [1:0]        op_cls,
  input  logic [1:0]        width_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_cout,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c,
  output logic              flag_a,
  output logic              flag_p
);

  logic      a_msb, b_msb, r_msb, r_zero;
  logic      ovf, cry, aux;
  op_class_e op;
  flag_set_t nxt, flags_q;

  assign op = op_class_e'(op_cls);

  psw_width_sel #(
    .DATA_W(DATA_W),
    .BASE_W(BASE_W),
    .NUM_W (NUM_W)
  ) u_wsel (
    .width_sel (width_sel),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .alu_result(alu_result),
    .a_msb     (a_msb),
    .b_msb     (b_msb),
    .r_msb     (r_msb),
    .r_zero    (r_zero)
  );

  psw_arith_flags u_arith (
    .op      (op),
    .a_msb   (a_msb),
    .b_msb   (b_msb),
    .r_msb   (r_msb),
    .a_nib   (opnd_a[AUX_BIT]),
    .b_nib   (opnd_b[AUX_BIT]),
    .r_nib   (alu_result[AUX_BIT]),
    .alu_cout(alu_cout),
    .ovf     (ovf),
    .cry     (cry),
    .aux     (aux)
  );

  always_comb begin
    nxt.neg  = r_msb;
    nxt.zero = r_zero;
    nxt.ovf  = ovf;
    nxt.cry  = cry;
    nxt.aux  = aux;
    nxt.par  = ~^alu_result[PAR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)         flags_q <= '0;
    else if (upd_en) flags_q <= nxt;
  end

  assign flag_n = flags_q.neg;
  assign flag_z = flags_q.zero;
  assign flag_v = flags_q.ovf;
  assign flag_c = flags_q.cry;
  assign flag_a = flags_q.aux;
  assign flag_p = flags_q.par;

  // ---------------- assertions ----------------
  p_reset_clear_r9: assert property (@(posedge clk)
    $past(rst) |-> (flags_q == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(upd_en)) |-> $stable(flags_q));

  p_logic_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(upd_en) && $past(op_cls[1])) |-> (!flag_c && !flag_v && !flag_a));

  p_add_carry_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(upd_en) && ($past(op_cls) == 2'd0)) |-> (flag_c == $past(alu_cout)));

  p_sub_borrow_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(upd_en) && ($past(op_cls) == 2'd1)) |-> (flag_c != $past(alu_cout)));

  p_zero_not_neg_r2: assert property (@(posedge clk) disable iff (rst)
    flag_z |-> !flag_n);

  p_zero_even_r7: assert property (@(posedge clk) disable iff (rst)
    flag_z |-> flag_p);

endmodule

// File: tb/sim_psw_flag_gen.sv
`timescale 1ns/1ps
module sim_psw_flag_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_en = 1'b0;
  logic [1:0]  op_cls = 2'd0;
  logic [1:0]  width_sel = 2'd0;
  logic [31:0] opnd_a = '0, opnd_b = '0, alu_result = '0;
  logic        alu_cout = 1'b0;
  logic        flag_n, flag_z, flag_v, flag_c, flag_a, flag_p;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  logic [5:0] exp_q = '0;

  always #2 clk = ~clk;

  psw_flag_gen u0 (
    .clk(clk), .rst(rst), .upd_en(upd_en), .op_cls(op_cls), .width_sel(width_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .alu_result(alu_result), .alu_cout(alu_cout),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .flag_a(flag_a), .flag_p(flag_p)
  );

  function automatic int wbits(input logic [1:0] ws);
    if (ws == 2'd0) return 8;
    if (ws == 2'd1) return 16;
    return 32;
  endfunction

  // flag order {N,Z,V,C,A,P}
  function automatic logic [5:0] model(input logic [1:0] op, input logic [1:0] ws,
                                       input logic [31:0] a, input logic [31:0] b,
                                       input logic [31:0] r);
    int w = wbits(ws);
    longint m  = (longint'(1) << w) - 1;
    longint au = longint'(a) & m;
    longint bu = longint'(b) & m;
    longint ru = longint'(r) & m;
    longint half = longint'(1) << (w - 1);
    longint sa = (au >= half) ? au - (longint'(1) << w) : au;
    longint sb = (bu >= half) ? bu - (longint'(1) << w) : bu;
    longint s;
    logic n, z, v, c, x, p;
    n = (ru >= half);
    z = (ru == 0);
    p = ~^r[7:0];
    v = 1'b0; c = 1'b0; x = 1'b0;
    if (op == 2'd0) begin
      s = sa + sb;
      v = (s >= half) || (s < -half);
      c = (au + bu) > m;
      x = (int'(a[3:0]) + int'(b[3:0])) > 15;
    end else if (op == 2'd1) begin
      s = sa - sb;
      v = (s >= half) || (s < -half);
      c = au < bu;
      x = a[3:0] < b[3:0];
    end
    return {n, z, v, c, x, p};
  endfunction

  task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got NZVCAP=%b expected %b", tag, got, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {flag_n, flag_z, flag_v, flag_c, flag_a, flag_p};
  endfunction

  // plays the ALU: forms result and raw carry, then drives one cycle
  task automatic run_op(input logic [1:0] op, input logic [1:0] ws, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] junk, input logic en,
                        input string tag);
    int w = wbits(ws);
    logic [32:0] t;
    logic [31:0] mask, r;
    logic cy;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    if (op == 2'd0) begin
      t  = {1'b0, a & mask} + {1'b0, b & mask};
      cy = t[w];
      r  = (t[31:0] & mask) | (junk & ~mask);
    end else if (op == 2'd1) begin
      t  = {1'b0, a & mask} + {1'b0, ~b & mask} + 33'd1;
      cy = t[w];
      r  = (t[31:0] & mask) | (junk & ~mask);
    end else begin
      case (junk[1:0])
        2'd0: r = a & b;
        2'd1: r = a | b;
        default: r = a ^ b;
      endcase
      cy = junk[31];
    end
    @(negedge clk);
    op_cls = op; width_sel = ws; opnd_a = a; opnd_b = b;
    alu_result = r; alu_cout = cy; upd_en = en;
    if (en) exp_q = model(op, ws, a, b, r);
    @(posedge clk);
    @(negedge clk);
    check(tag, outs(), exp_q);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset state", outs(), 6'b0);
    rst = 1'b0;

    // directed corners
    run_op(2'd0, 2'd0, 32'h7F, 32'h01, 32'h0, 1'b1, "R1 R3 R5 byte 7F+01");
    run_op(2'd0, 2'd0, 32'hFF, 32'h01, 32'hABCD_EF00, 1'b1, "R2 R4 R7 byte FF+01 junk above");
    run_op(2'd0, 2'd0, 32'h80, 32'h80, 32'h0, 1'b1, "R3 R4 C and V together 80+80");
    run_op(2'd1, 2'd0, 32'h00, 32'h01, 32'h0, 1'b1, "R4 R5 borrow 00-01");
    run_op(2'd1, 2'd0, 32'h80, 32'h01, 32'h0, 1'b1, "R3 sub overflow 80-01");
    run_op(2'd0, 2'd1, 32'h7FFF, 32'h1, 32'h0, 1'b1, "R10 R1 half 7FFF+1");
    run_op(2'd0, 2'd1, 32'h00FF, 32'h1, 32'h0, 1'b1, "R7 parity low byte only");
    run_op(2'd1, 2'd3, 32'h8000_0000, 32'h1, 32'h0, 1'b1, "R10 R3 code3 word");
    run_op(2'd2, 2'd2, 32'hF0F0_0000, 32'hFFFF_0000, 32'h8000_0000, 1'b1, "R6 logic clears, cout ignored");
    run_op(2'd3, 2'd0, 32'h0000_0080, 32'h0000_0080, 32'h8000_0000, 1'b1, "R6 logic alt N");
    run_op(2'd0, 2'd0, 32'h01, 32'h02, 32'h0, 1'b0, "R8 hold with enable low");

    // reset colliding with an enabled update
    @(negedge clk);
    op_cls = 2'd0; width_sel = 2'd0; opnd_a = 32'h80; opnd_b = 32'h80;
    alu_result = 32'h0; alu_cout = 1'b1; upd_en = 1'b1; rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_q = '0;
    check("R9 reset beats update", outs(), 6'b0);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra = $urandom();
      logic [31:0] rb = $urandom();
      logic [31:0] rj = $urandom();
      logic [1:0]  rop = 2'($urandom_range(3, 0));
      logic [1:0]  rws = 2'($urandom_range(3, 0));
      logic        ren = ($urandom_range(7, 0) != 0);
      if ($urandom_range(3, 0) == 0) rb = ra;
      run_op(rop, rws, ra, rb, rj, ren, "R1 R2 R3 R4 R5 R6 R7 R8 R10 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule